// File: doc/BRIEF.md
# Slew-Limited Servo Pulse Generator

This block drives one hobby servo. It produces a pulse train with a fixed frame. The high time of each pulse depends on a position register. A 10-bit target sets where the servo should end up. The position register does not copy the target. At each frame boundary it moves one count toward the target, or stays put if it already matches. A large target step therefore becomes a steady ramp of one count per frame. A full sweep from 0 to 1023 takes 1023 frames.

The target is a plain control input and may come from any clock domain. It passes through a two-stage synchronizer before the block compares it with the position. The position and the pulse width change only at the frame boundary, so the pulse being emitted is never altered. After reset the block spends one frame loading the synchronized target into the position, with the output held low. The first pulse then starts at that width, so there is no ramp at power-up.

No data streams through the block. All pins are plain level signals with no handshake. The defaults give a 20 ms frame, 1.0 ms and 2.0 ms width limits, and a 50 MHz clock. The width limits are parameters, so a 0.5–2.5 ms range is a matter of changing two numbers.

Top module: `servo_slew_pwm`

## Requirements
- R1: The frame counter runs from 0 to FRAME_CYC-1 and then wraps to 0. Consecutive pulse rising edges are exactly FRAME_CYC cycles apart.
- R2: The pulse width in cycles is MIN_CYC + floor(position × (MAX_CYC − MIN_CYC) / (2^POS_W − 1)). Position 0 gives MIN_CYC and position 2^POS_W − 1 gives MAX_CYC.
- R3: pwm_o is high for the first width cycles of a frame and low for the remaining FRAME_CYC − width cycles. Each pulse rises in the cycle where the frame counter is 0.
- R4: At each frame boundary the position moves +1 if the synchronized target is above it and −1 if the target is below it. It holds if the two are equal.
- R5: The position and the pulse width change only at a frame boundary. A target change during a pulse does not alter that pulse.
- R6: While rst_n is low, pwm_o is 0, position_o is 0 and at_target_o is 0. During the first frame after reset pwm_o stays low and the position follows the synchronized target. From the next frame on, pulses use that loaded position with no ramp.
- R7: at_target_o is 1 when the block has passed its first frame after reset and the position equals the synchronized target. Otherwise it is 0.
- R8: The target reaches the comparison through two register stages. A target driven while the frame counter is FRAME_CYC−2 is ignored at the boundary that follows. A target driven while the counter is FRAME_CYC−3 is acted on at that boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| target_i | input | POS_W | Target position, may be asynchronous |
| pwm_o | output | 1 | Servo control pulse |
| position_o | output | POS_W | Current internal position |
| at_target_o | output | 1 | Position equals synchronized target |

## Verification
Each kind of internal fault shows up at the pins within a bounded time:
- A position register that skips, overshoots or moves mid-frame appears on position_o in the cycle it happens. It also appears in the width of the next pulse, one frame later at most.
- A wrong width product or divide changes the high time of the very next pulse. The bench places some positions where the floor of the divide changes by one, so a rounding fault is visible.
- A frame counter fault moves the spacing between rising edges.
- A synchronizer with the wrong depth shifts which boundary acts on a target change. The bench drives targets two and three cycles before a boundary to show this within one frame.

// File: rtl/servo_pkg.sv
package servo_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  // width = lo + floor(p * span / pmax)
  function automatic longint unsigned pulse_cycles(
    input longint unsigned p,
    input longint unsigned lo,
    input longint unsigned span,
    input longint unsigned pmax
  );
    return lo + (p * span) / pmax;
  endfunction

endpackage

// File: rtl/servo_sync2.sv
module servo_sync2 #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;

  // R8
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |=> stab_q == $past(meta_q));

endmodule

// File: rtl/servo_frame_timer.sv
module servo_frame_timer #(
  parameter int unsigned FRAME_CYC = 1_000_000,
  parameter int unsigned CNT_W     = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_d,
  output logic             frame_end
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_CYC - 1);

  assign frame_end = (cnt_q == LAST);
  assign cnt_d     = frame_end ? '0 : cnt_q + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R1
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == LAST) |=> (cnt_q == '0));

endmodule

// File: rtl/servo_slew_reg.sv
module servo_slew_reg
  import servo_pkg::*;
#(
  parameter int unsigned POS_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_end,
  input  logic [POS_W-1:0] tgt_s,
  output logic [POS_W-1:0] pos_q,
  output logic [POS_W-1:0] pos_d,
  output logic             at_tgt
);

  step_e step;
  logic  primed_q;

  always_comb begin
    if (tgt_s > pos_q)      step = STEP_UP;
    else if (tgt_s < pos_q) step = STEP_DOWN;
    else                    step = STEP_HOLD;
  end

  always_comb begin
    pos_d = pos_q;
    if (!primed_q) begin
      pos_d = tgt_s;
    end else if (frame_end) begin
      case (step)
        STEP_UP:   pos_d = pos_q + POS_W'(1);
        STEP_DOWN: pos_d = pos_q - POS_W'(1);
        default:   pos_d = pos_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q    <= '0;
      primed_q <= 1'b0;
    end else begin
      pos_q    <= pos_d;
      primed_q <= primed_q | frame_end;
    end
  end

  assign at_tgt = primed_q & (step == STEP_HOLD);

  // R4
  pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && frame_end) |=>
      (pos_q == $past(pos_q)) || (pos_q == $past(pos_q) + POS_W'(1)) ||
      (pos_q == $past(pos_q) - POS_W'(1)));

  // R4
  pos_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && frame_end && (tgt_s > pos_q)) |=> (pos_q > $past(pos_q)));

  // R5
  pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && !frame_end) |=> $stable(pos_q));

endmodule

// File: rtl/servo_pulse_gen.sv
module servo_pulse_gen
  import servo_pkg::*;
#(
  parameter int unsigned CNT_W   = 20,
  parameter int unsigned POS_W   = 10,
  parameter int unsigned MIN_CYC = 50_000,
  parameter int unsigned MAX_CYC = 100_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_end,
  input  logic [CNT_W-1:0] cnt_d,
  input  logic [POS_W-1:0] pos_d,
  output logic             pwm_q,
  output logic [CNT_W-1:0] width_q
);

  localparam longint unsigned SPAN_L = 64'(MAX_CYC - MIN_CYC);
  localparam longint unsigned PMAX_L = 64'((2 ** POS_W) - 1);
  localparam longint unsigned LO_L   = 64'(MIN_CYC);

  logic [CNT_W-1:0] width_new;
  logic [CNT_W-1:0] width_d;

  always_comb begin
    width_new = CNT_W'(pulse_cycles(64'(pos_d), LO_L, SPAN_L, PMAX_L));
    width_d   = frame_end ? width_new : width_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_q <= '0;
      pwm_q   <= 1'b0;
    end else begin
      width_q <= width_d;
      pwm_q   <= (cnt_d < width_d);
    end
  end

  // R5
  width_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(width_q));

  // R2
  width_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (width_q == '0) ||
    ((width_q >= CNT_W'(MIN_CYC)) && (width_q <= CNT_W'(MAX_CYC))));

endmodule

// File: rtl/servo_slew_pwm.sv
module servo_slew_pwm #(
  parameter int unsigned FRAME_CYC = 1_000_000,
  parameter int unsigned MIN_CYC   = 50_000,
  parameter int unsigned MAX_CYC   = 100_000,
  parameter int unsigned POS_W     = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] target_i,
  output logic             pwm_o,
  output logic [POS_W-1:0] position_o,
  output logic             at_target_o
);

  localparam int unsigned CNT_W = $clog2(FRAME_CYC + 1);

  logic [POS_W-1:0] tgt_s;
  logic [POS_W-1:0] pos_d;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] width_q;
  logic             frame_end;

  servo_sync2 #(.W(POS_W)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (target_i),
    .q_o   (tgt_s)
  );

  servo_frame_timer #(.FRAME_CYC(FRAME_CYC), .CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_q     (cnt_q),
    .cnt_d     (cnt_d),
    .frame_end (frame_end)
  );

  servo_slew_reg #(.POS_W(POS_W)) u_slew (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_end (frame_end),
    .tgt_s     (tgt_s),
    .pos_q     (position_o),
    .pos_d     (pos_d),
    .at_tgt    (at_target_o)
  );

  servo_pulse_gen #(
    .CNT_W  (CNT_W),
    .POS_W  (POS_W),
    .MIN_CYC(MIN_CYC),
    .MAX_CYC(MAX_CYC)
  ) u_pulse (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_end (frame_end),
    .cnt_d     (cnt_d),
    .pos_d     (pos_d),
    .pwm_q     (pwm_o),
    .width_q   (width_q)
  );

  // R3
  pwm_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_o) |-> (cnt_q == '0));

  // R3
  pwm_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwm_o) |-> (cnt_q == width_q));

endmodule

// File: tb/servo_slew_pwm_tb_top.sv
module servo_slew_pwm_tb_top;

  localparam int F    = 200;
  localparam int LO   = 40;
  localparam int HI   = 100;
  localparam int PMAX = 1023;

  // table columns: target, frames to observe, expected position, expected flag
  localparam int NV = 6;
  localparam int VEC [NV][4] = '{
    '{515, 1, 513, 0},
    '{515, 2, 515, 1},
    '{515, 2, 515, 1},
    '{510, 3, 512, 0},
    '{510, 2, 510, 1},
    '{1023, 1, 511, 0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] tgt = 10'd512;
  logic       pwm;
  logic [9:0] pos;
  logic       at;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  servo_slew_pwm #(.FRAME_CYC(F), .MIN_CYC(LO), .MAX_CYC(HI), .POS_W(10)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .target_i    (tgt),
    .pwm_o       (pwm),
    .position_o  (pos),
    .at_target_o (at)
  );

  function automatic int expw(input int p);
    return LO + (p * (HI - LO)) / PMAX;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_rise(output int t);
    do @(negedge clk); while (pwm !== 1'b0);
    do @(negedge clk); while (pwm !== 1'b1);
    t = cyc;
  endtask

  task automatic measure(output int w, output int t);
    wait_rise(t);
    w = 1;
    forever begin
      @(negedge clk);
      if (pwm !== 1'b1) break;
      w++;
    end
  endtask

  task automatic reset_load(input int t);
    int hi;
    int w;
    int tr;
    @(negedge clk);
    rst_n = 1'b0;
    tgt = 10'(t);
    repeat (3) @(negedge clk);
    check(pwm == 1'b0, "R6 reset pwm", int'(pwm), 0);
    check(pos == 10'd0, "R6 reset position", int'(pos), 0);
    check(at == 1'b0, "R6 reset flag", int'(at), 0);
    rst_n = 1'b1;
    hi = 0;
    for (int i = 0; i < F - 3; i++) begin
      @(negedge clk);
      if (pwm === 1'b1) hi++;
    end
    check(hi == 0, "R6 first frame silent", hi, 0);
    measure(w, tr);
    check(w == expw(t), "R2 R6 loaded width", w, expw(t));
    check(int'(pos) == t, "R6 loaded position", int'(pos), t);
    check(at == 1'b1, "R7 flag after load", int'(at), 1);
  endtask

  initial begin
    int w0, w1, t0, t1, w, t, p;
    int rl [4] = '{0, 1023, 17, 18};

    reset_load(512);

    // R1 frame spacing, R3 low time
    measure(w0, t0);
    measure(w1, t1);
    check(t1 - t0 == F, "R1 rise spacing", t1 - t0, F);
    check((t1 - t0) - w0 == F - expw(512), "R3 low time", (t1 - t0) - w0, F - expw(512));
    check(w1 == 70, "R2 width at 512", w1, 70);

    // R4 R7 table walk
    for (int v = 0; v < NV; v++) begin
      tgt = 10'(VEC[v][0]);
      for (int k = 0; k < VEC[v][1]; k++) measure(w, t);
      check(int'(pos) == VEC[v][2], "R4 position step", int'(pos), VEC[v][2]);
      check(w == expw(VEC[v][2]), "R2 R4 width follows position", w, expw(VEC[v][2]));
      check(int'(at) == VEC[v][3], "R7 at-target flag", int'(at), VEC[v][3]);
    end

    // R5 target change in mid-pulse does not touch the pulse
    tgt = 10'd511;
    measure(w, t);
    measure(w, t);
    p = int'(pos);
    wait_rise(t);
    w = 1;
    forever begin
      @(negedge clk);
      if (w == 5) tgt = 10'd0;
      if (pwm !== 1'b1) break;
      w++;
    end
    check(w == expw(p), "R5 pulse kept", w, expw(p));
    check(int'(pos) == p, "R5 position kept mid-frame", int'(pos), p);
    measure(w, t);
    check(int'(pos) == p - 1, "R5 R4 step after boundary", int'(pos), p - 1);

    // R8 synchronizer latency
    tgt = pos;
    measure(w, t);
    p = int'(pos);
    wait_rise(t);
    repeat (F - 2) @(negedge clk);
    tgt = 10'(p + 5);
    measure(w, t);
    check(int'(pos) == p, "R8 late target ignored", int'(pos), p);
    measure(w, t);
    check(int'(pos) == p + 1, "R8 target seen next boundary", int'(pos), p + 1);
    wait_rise(t);
    repeat (F - 3) @(negedge clk);
    tgt = 10'(p - 5);
    measure(w, t);
    check(int'(pos) == p + 1, "R8 early target acted on", int'(pos), p + 1);

    // R2 R6 reset loads at range ends and rounding points
    for (int i = 0; i < 4; i++) reset_load(rl[i]);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule